// File: doc/BRIEF.md
# Keyed Configuration Item Access Port

This block is a small register-mapped window through which boot firmware pulls configuration items out of on-chip storage. Each item is a short byte string with its own length. An item is chosen by a 16-bit selector key. Key bit 15 picks one of two item banks: bank 0 is shared and bank 1 is local to the architecture. Key bits 13:0 give the entry index. Key bit 14 is ignored. Writing a key chooses an item and rewinds its read cursor. Each data read then returns the next bytes of that item, with the first byte in the most significant position. Bytes past the end of the item read as zero.

Firmware reaches the block through one of three port codes. One is a control port that takes selector writes. One is a data port. The third is a combined port that carries both, with the access size deciding the meaning. A request that is accepted returns exactly one response. A rejected request returns a response with a clear status and changes nothing. A write-only preload interface fills the item bytes and lengths. It stands in for the host-side storage that loads items.

Inside, a three-state machine serves each request. The states and transitions are:
- ST_IDLE: the block takes a request. It moves to ST_SHIFT on an accepted data read. It moves to ST_RESP on any other request.
- ST_SHIFT: the block gathers one byte per cycle. It stays in ST_SHIFT while bytes remain. It moves to ST_RESP after the last byte.
- ST_RESP: the block presents the response for one cycle, then returns to ST_IDLE.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selection is key 0 (bank 0, index 0) with the cursor at byte 0. The port is ready, and no response is pending.
- R2: An accepted selector write always sets the cursor back to byte 0, so the next read starts at the first byte of the item.
- R3: Key bit 15 chooses the bank, key bits 13:0 give the index, and key bit 14 is ignored. The entry limit is FIRST_FILE + FILE_SLOTS, which is 64 by default. An index at or above the limit makes the selection invalid.
- R4: A data read of size code k returns N = 2^k bytes. Item bytes from the cursor fill the low N bytes, with the first byte most significant. Bits above the low N bytes are zero.
- R5: When fewer than N item bytes remain, the available bytes are followed by zero bytes on the right. The cursor stops at the item length.
- R6: A data read returns zero and leaves the cursor where it is when the selection is invalid, when the item is empty, or when the cursor has reached the length.
- R7: Port code 2 (combined) treats a size-code-0 access as a data access and a size-code-1 write as a selector write. Every other access on it is rejected.
- R8: Port code 0 (control) accepts only size-code-1 writes. A read of it, or a write of any other size, is rejected and responds with zero.
- R9: Writes to port code 1 (data), and size-code-0 writes to the combined port, are accepted. They do not change the selection or the cursor.
- R10: Port code 3 rejects everything. A rejected request responds with rsp_ok low and data zero, and changes no state.
- R11: req_ready is high only in ST_IDLE. A non-read response is visible right after the edge that accepts the request. An N-byte data read responds N edges after acceptance.
- R12: A preload write stores one data byte at (bank, index, byte address) and sets that entry's length. Later reads see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | 0 control, 1 data, 2 combined, 3 unmapped |
| req_size | input | 2 | Size code k, access of 2^k bytes |
| req_wdata | input | 16 | Selector key for selector writes |
| req_ready | output | 1 | Block is idle and can take a request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_ok | output | 1 | Request was accepted |
| rsp_data | output | 64 | Read result, zero for non-reads |
| ld_we | input | 1 | Preload write strobe |
| ld_bank | input | 1 | Preload bank |
| ld_index | input | 6 | Preload entry index |
| ld_addr | input | 3 | Preload byte address in the item |
| ld_byte | input | 8 | Preload data byte |
| ld_len | input | 4 | Item length written with the byte |

## Verification
The hardest case to reach from the ports is a read that runs off the end of an item part way through. It has to deliver real bytes, then zero padding, and then leave the cursor fixed at the length, so that later reads return only zeros. The stimulus reaches this state by reading a six-byte item with a two-byte read, then a one-byte read, then an eight-byte read, and then reading again. A second difficult point is proving that rejected and ignored accesses leave the cursor alone. To show this, the stimulus places each such access between single-byte reads of a known item. Any rewind or skip then shows up as a wrong byte.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        PORT_CTRL = 2'd0,
        PORT_DATA = 2'd1,
        PORT_COMB = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        OP_SELECT = 2'd0,
        OP_READ   = 2'd1,
        OP_IGNORE = 2'd2,
        OP_REJECT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    localparam int KEY_W     = 16;
    localparam int KEY_IDX_W = 14;
    localparam int BANK_BIT  = 15;
    localparam int DATA_W    = 64;
    localparam int OFS_W     = 32;

endpackage

// File: rtl/cfg_item_store.sv
module cfg_item_store #(
    parameter int LIMIT   = 64,
    parameter int MAX_LEN = 8,
    parameter int IDX_W   = 6,
    parameter int ADDR_W  = 3,
    parameter int LEN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              ld_bank,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_byte,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [LEN_W-1:0]  rd_len
);

    localparam int ENTRIES = 2 * LIMIT;
    localparam int DEPTH   = ENTRIES * MAX_LEN;
    localparam int SLOT_W  = $clog2(ENTRIES);
    localparam int MEM_W   = $clog2(DEPTH);

    logic [7:0]       mem     [DEPTH];
    logic [LEN_W-1:0] len_tab [ENTRIES];

    function automatic logic [SLOT_W-1:0] slot_of(input logic bank, input logic [IDX_W-1:0] idx);
        return SLOT_W'(int'(bank) * LIMIT + int'(idx));
    endfunction

    function automatic logic [MEM_W-1:0] cell_of(input logic bank, input logic [IDX_W-1:0] idx,
                                                 input logic [ADDR_W-1:0] a);
        return MEM_W'((int'(bank) * LIMIT + int'(idx)) * MAX_LEN + int'(a));
    endfunction

    logic ld_hit;
    assign ld_hit = ld_we && (int'(ld_index) < LIMIT) && (int'(ld_addr) < MAX_LEN);

    always_ff @(posedge clk) begin
        if (ld_hit) begin
            mem[cell_of(ld_bank, ld_index, ld_addr)] <= ld_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                len_tab[e] <= '0;
            end
        end else if (ld_hit) begin
            len_tab[slot_of(ld_bank, ld_index)] <= ld_len;
        end
    end

    always_comb begin
        rd_byte = mem[cell_of(rd_bank, rd_index, rd_addr)];
        rd_len  = len_tab[slot_of(rd_bank, rd_index)];
    end

    // R12: preload only addresses real entries with legal lengths
    p_load_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> ((int'(ld_index) < LIMIT) && (int'(ld_len) <= MAX_LEN)));

endmodule

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
    import cfg_port_pkg::*;
(
    input  logic [1:0] req_port,
    input  logic       req_write,
    input  logic [1:0] req_size,
    output op_e        op
);

    always_comb begin
        op = OP_REJECT;
        unique case (port_e'(req_port))
            PORT_CTRL: begin
                if (req_write && req_size == 2'd1) op = OP_SELECT;
            end
            PORT_DATA: begin
                op = req_write ? OP_IGNORE : OP_READ;
            end
            PORT_COMB: begin
                if (req_size == 2'd0)                  op = req_write ? OP_IGNORE : OP_READ;
                else if (req_size == 2'd1 && req_write) op = OP_SELECT;
            end
            PORT_NONE: op = OP_REJECT;
            default:   op = OP_REJECT;
        endcase
    end

endmodule

// File: rtl/cfg_read_engine.sv
module cfg_read_engine
    import cfg_port_pkg::*;
#(
    parameter int LIMIT   = 64,
    parameter int MAX_LEN = 8,
    parameter int IDX_W   = 6,
    parameter int ADDR_W  = 3,
    parameter int LEN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               op,
    input  logic [1:0]        size_code,
    input  logic [KEY_W-1:0]  key,
    input  logic [7:0]        rd_byte,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              rd_bank,
    output logic [IDX_W-1:0]  rd_index,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int CNT_W = 4;

    state_e              state, state_nx;
    logic                sel_valid;
    logic                sel_bank;
    logic [IDX_W-1:0]    sel_idx;
    logic [OFS_W-1:0]    offset;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   acc;
    logic                ok_q;
    logic [1:0]          size_q;

    logic                key_ok;
    logic                avail;
    logic                key_unused;

    assign key_unused = key[KEY_IDX_W];
    assign key_ok     = ({{(OFS_W-KEY_IDX_W){1'b0}}, key[KEY_IDX_W-1:0]} < OFS_W'(LIMIT));
    assign avail      = sel_valid && (offset < {{(OFS_W-LEN_W){1'b0}}, rd_len});

    assign rd_bank  = sel_bank;
    assign rd_index = sel_idx;
    assign rd_addr  = offset[ADDR_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = (op == OP_READ) ? ST_SHIFT : ST_RESP;
            ST_SHIFT: if (cnt == CNT_W'(1)) state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // selection, cursor and accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b1;
            sel_bank  <= 1'b0;
            sel_idx   <= '0;
            offset    <= '0;
            cnt       <= '0;
            acc       <= '0;
            ok_q      <= 1'b0;
            size_q    <= 2'd0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ok_q   <= (op != OP_REJECT);
                        acc    <= '0;
                        size_q <= size_code;
                        cnt    <= CNT_W'(1 << size_code);
                        if (op == OP_SELECT) begin
                            offset    <= '0;
                            sel_valid <= key_ok;
                            if (key_ok) begin
                                sel_bank <= key[BANK_BIT];
                                sel_idx  <= key[IDX_W-1:0];
                            end
                        end
                    end
                end
                ST_SHIFT: begin
                    acc <= {acc[DATA_W-9:0], (avail ? rd_byte : 8'h00)};
                    cnt <= cnt - CNT_W'(1);
                    if (avail) offset <= offset + OFS_W'(1);
                end
                ST_RESP: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ready     = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_ok    = (state == ST_RESP) && ok_q;
        rsp_data  = (state == ST_RESP) ? acc : '0;
    end

    // R2: a selector write rewinds the cursor
    p_select_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && op == OP_SELECT) |=> (offset == '0));

    // R4: nothing above the requested byte count
    p_read_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q != 2'd3) |-> ((rsp_data >> (8 << size_q)) == '0));

    // R5: cursor never passes the largest item
    p_offset_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= OFS_W'(MAX_LEN));

    // R6: an invalid selection never advances the cursor
    p_invalid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !sel_valid) |=> $stable(offset));

    // R10: a rejected request answers with zero and a clear status
    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && op == OP_REJECT) |=> (rsp_valid && !rsp_ok && rsp_data == '0));

    // R11: an accepted request always makes the port busy
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_port_pkg::*;
#(
    parameter int FIRST_FILE = 32,
    parameter int FILE_SLOTS = 32,
    parameter int MAX_LEN    = 8,
    localparam int LIMIT     = FIRST_FILE + FILE_SLOTS,
    localparam int IDX_W     = $clog2(LIMIT),
    localparam int ADDR_W    = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_port,
    input  logic [1:0]        req_size,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [63:0]       rsp_data,
    input  logic              ld_we,
    input  logic              ld_bank,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_byte,
    input  logic [LEN_W-1:0]  ld_len
);

    op_e               op;
    logic              rd_bank;
    logic [IDX_W-1:0]  rd_index;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_byte;
    logic [LEN_W-1:0]  rd_len;

    cfg_req_decode u_decode (
        .req_port  (req_port),
        .req_write (req_write),
        .req_size  (req_size),
        .op        (op)
    );

    cfg_item_store #(
        .LIMIT   (LIMIT),
        .MAX_LEN (MAX_LEN),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_bank  (ld_bank),
        .ld_index (ld_index),
        .ld_addr  (ld_addr),
        .ld_byte  (ld_byte),
        .ld_len   (ld_len),
        .rd_bank  (rd_bank),
        .rd_index (rd_index),
        .rd_addr  (rd_addr),
        .rd_byte  (rd_byte),
        .rd_len   (rd_len)
    );

    cfg_read_engine #(
        .LIMIT   (LIMIT),
        .MAX_LEN (MAX_LEN),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .op        (op),
        .size_code (req_size),
        .key       (req_wdata),
        .rd_byte   (rd_byte),
        .rd_len    (rd_len),
        .rd_bank   (rd_bank),
        .rd_index  (rd_index),
        .rd_addr   (rd_addr),
        .ready     (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_data  (rsp_data)
    );

endmodule

// File: tb/tb_cfg_item_port.sv
module tb_cfg_item_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_port = 2'd0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [63:0] rsp_data;
    logic        ld_we = 1'b0;
    logic        ld_bank = 1'b0;
    logic [5:0]  ld_index = 6'd0;
    logic [2:0]  ld_addr = 3'd0;
    logic [7:0]  ld_byte = 8'd0;
    logic [3:0]  ld_len = 4'd0;

    always #5 clk = ~clk;

    cfg_item_port dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_port(req_port),
        .req_size(req_size), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .ld_we(ld_we), .ld_bank(ld_bank), .ld_index(ld_index), .ld_addr(ld_addr),
        .ld_byte(ld_byte), .ld_len(ld_len)
    );

    typedef struct {
        logic        ok;
        logic [63:0] data;
        int          lat;
        int          acc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R11 unexpected response", rsp_data, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_ok == e.ok, {e.tag, " status"}, 64'(rsp_ok), 64'(e.ok));
                check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
                check((cyc - e.acc) == e.lat, "R11 latency", 64'(cyc - e.acc), 64'(e.lat));
            end
        end
    end

    task automatic load(input logic bank, input logic [5:0] idx, input logic [2:0] a,
                        input logic [7:0] b, input logic [3:0] len);
        @(negedge clk);
        ld_we = 1'b1; ld_bank = bank; ld_index = idx; ld_addr = a; ld_byte = b; ld_len = len;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // driver: pushes the expectation and issues one request
    task automatic access(input logic [1:0] port, input logic wr, input logic [1:0] sz,
                          input logic [15:0] wd, input logic eok, input logic [63:0] edata,
                          input string tag);
        exp_t e;
        bit is_read;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        is_read = !wr && (port == 2'd1 || (port == 2'd2 && sz == 2'd0));
        e.ok = eok; e.data = edata; e.tag = tag;
        e.lat = is_read ? (1 << sz) : 0;
        e.acc = cyc + 1;
        q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_port = port; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sel(input logic [15:0] key, input string tag);
        access(2'd0, 1'b1, 2'd1, key, 1'b1, 64'd0, tag);
    endtask

    task automatic rd(input logic [1:0] sz, input logic [63:0] edata, input string tag);
        access(2'd1, 1'b0, sz, 16'd0, 1'b1, edata, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R11 watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        check(rsp_data == 64'd0, "R1 data after reset", rsp_data, 64'd0);

        // item contents
        load(1'b0, 6'd0, 3'd0, 8'h43, 4'd4); load(1'b0, 6'd0, 3'd1, 8'h46, 4'd4);
        load(1'b0, 6'd0, 3'd2, 8'h47, 4'd4); load(1'b0, 6'd0, 3'd3, 8'h58, 4'd4);
        for (int i = 0; i < 6; i++) load(1'b0, 6'd5, 3'(i), 8'(8'h11 * (i + 1)), 4'd6);
        for (int i = 0; i < 3; i++) load(1'b1, 6'd5, 3'(i), 8'(8'hA1 + i), 4'd3);
        for (int i = 0; i < 8; i++) load(1'b0, 6'd63, 3'(i), 8'(i + 1), 4'd8);

        rd(2'd2, 64'h43464758, "R1 R4 reset selection reads key 0");
        rd(2'd0, 64'd0, "R6 exhausted item");
        sel(16'h0005, "R2 select key 5");
        rd(2'd1, 64'h1122, "R4 two-byte read");
        access(2'd2, 1'b0, 2'd0, 16'd0, 1'b1, 64'h33, "R7 combined byte read");
        rd(2'd3, 64'h4455660000000000, "R5 padded eight-byte read");
        rd(2'd2, 64'd0, "R6 read at end");
        access(2'd2, 1'b1, 2'd1, 16'h8005, 1'b1, 64'd0, "R7 combined select");
        rd(2'd2, 64'hA1A2A300, "R3 R5 bank 1 item");
        sel(16'h0005, "R2 reselect");
        rd(2'd0, 64'h11, "R2 cursor rewound");
        access(2'd0, 1'b1, 2'd0, 16'h003F, 1'b0, 64'd0, "R8 control byte write");
        access(2'd0, 1'b0, 2'd1, 16'd0, 1'b0, 64'd0, "R8 control read");
        rd(2'd0, 64'h22, "R8 rejected control kept cursor");
        access(2'd2, 1'b0, 2'd1, 16'd0, 1'b0, 64'd0, "R7 combined two-byte read");
        access(2'd2, 1'b1, 2'd2, 16'h003F, 1'b0, 64'd0, "R7 combined four-byte write");
        rd(2'd0, 64'h33, "R7 rejected combined kept cursor");
        access(2'd1, 1'b1, 2'd2, 16'h003F, 1'b1, 64'd0, "R9 data write");
        access(2'd2, 1'b1, 2'd0, 16'h003F, 1'b1, 64'd0, "R9 combined byte write");
        rd(2'd0, 64'h44, "R9 writes left cursor");
        access(2'd3, 1'b0, 2'd0, 16'd0, 1'b0, 64'd0, "R10 unmapped read");
        access(2'd3, 1'b1, 2'd1, 16'h003F, 1'b0, 64'd0, "R10 unmapped write");
        rd(2'd0, 64'h55, "R10 unmapped kept cursor");
        sel(16'h0040, "R3 select index 64");
        rd(2'd1, 64'd0, "R3 index at limit invalid");
        access(2'd2, 1'b0, 2'd0, 16'd0, 1'b1, 64'd0, "R6 invalid combined read");
        sel(16'h003F, "R3 select index 63");
        rd(2'd3, 64'h0102030405060708, "R3 last valid index");
        sel(16'h4005, "R3 bit 14 ignored select");
        rd(2'd0, 64'h11, "R3 bit 14 ignored");
        sel(16'h0007, "R6 select empty");
        rd(2'd2, 64'd0, "R6 empty item");
        sel(16'hBFFF, "R3 select bank 1 large index");
        rd(2'd0, 64'd0, "R3 large index invalid");
        load(1'b0, 6'd5, 3'd0, 8'h99, 4'd6);
        load(1'b0, 6'd7, 3'd0, 8'hEE, 4'd1);
        sel(16'h0005, "R12 reselect after load");
        rd(2'd0, 64'h99, "R12 reloaded byte");
        sel(16'h0007, "R12 select new item");
        rd(2'd1, 64'hEE00, "R12 R5 new one-byte item");

        for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R11 all responses seen", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule